// File: doc/BRIEF.md
# Emulated PHY Management Register File

This block is the register target that sits behind a management (MDIO-style) port whose far side is not a real transceiver. An external MAC that runs auto-negotiation polls the port as if a PHY were present. The block answers from a small register set. The set is built from latched board straps: speed, duplex, pause (flow control) and an active-low link indication. No negotiation is ever carried out. The status and advertisement that the MAC sees are fixed by configuration, although software may still rewrite the control bits and the advertised abilities.

Real storage exists only for the control register (address 0) and the advertisement register (address 4). The status register (address 1) is formed from the straps. A read of the link-partner ability register (address 5) returns whatever address 4 holds at that moment, so both ends of the link look identical. Every other address reads as zero and discards writes. The register view answers only while `view_en` is high, which means the port is in PHY-emulation mode and the MAC has auto-negotiation enabled.

A small controller tracks each request. It has four states:
- `ST_IDLE`: no request in the previous cycle.
- `ST_ACK_RD`: an accepted read.
- `ST_ACK_WR`: an accepted write.
- `ST_ACK_NOP`: a request that arrived while the view was disabled.

From any state, a request moves the controller to the matching acknowledge state, and a cycle with no request returns it to `ST_IDLE`. Read data is registered and is presented together with the ready pulse.

Top module: `phy_emu_regs`

## Requirements
- R1: Each cycle with `req_valid` high is followed, in the next cycle, by exactly one cycle of `rdy` high, including back-to-back requests. `rdy` stays low after a cycle with no request.
- R2: After reset, address 0 reads as follows: bit 13 equals `strap_speed100`, bit 12 is 1, bit 8 equals `strap_full_dup`, and all other bits are 0.
- R3: Address 1 reads as follows, from the straps present at the request:
  - bit 14 = speed AND duplex
  - bit 13 = speed
  - bit 12 = duplex
  - bit 11 = 1
  - bit 5 = 1 (negotiation complete)
  - bit 3 = 1
  - bit 2 = NOT `strap_link_n`
  - all other bits 0
- R4: After reset, address 4 reads as follows:
  - bits 4:0 = 00001
  - bit 5 = 1
  - bit 6 = duplex
  - bit 7 = speed
  - bit 8 = speed AND duplex
  - bit 10 = pause
  - all other bits 0
- R5: A read of address 5 returns the current contents of address 4, including a value written in the immediately preceding cycle.
- R6: A write to address 0 with bit 15 clear stores bits 14, 13, 12, 11, 10 and 8 (mask 0x7D00). Bits 15 and 9 and the remaining bits read back as 0.
- R7: A write to address 0 with bit 15 set restores both address 0 and address 4 to their strap-derived reset values, and the rest of that write data is discarded.
- R8: A write to address 4 stores bits 10:5 (mask 0x07E0). Bits 4:0 keep reading 00001 and bits 15:11 read 0.
- R9: Writes to address 1, address 5 and every unimplemented address change nothing. Reads of unimplemented addresses return 0x0000.
- R10: While `view_en` is low, reads return 0x0000 and writes change nothing, but `rdy` still pulses as in R1.
- R11: `rd_data` is 0x0000 whenever `rdy` is low and in the ready cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| view_en | input | 1 | Register view enabled (PHY-emulation mode with auto-negotiation on) |
| strap_speed100 | input | 1 | Latched speed strap, 1 = 100 Mb/s |
| strap_full_dup | input | 1 | Latched duplex strap, 1 = full duplex |
| strap_pause | input | 1 | Latched flow-control strap, 1 = pause advertised |
| strap_link_n | input | 1 | Latched link strap, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Read data, valid with `rdy` |
| rdy | output | 1 | One-cycle ready pulse for the previous cycle's request |

## Verification
Two functions can meet in a single cycle:
- the ready pulse for one request, together with the acceptance of the next request;
- a write to address 4 (or a soft-reset write to address 0), together with a read of the address-5 alias in the very next cycle.

The bench provokes both by issuing requests on consecutive clocks: write-then-alias-read pairs, and soft reset followed at once by reads. It judges every cycle against a behavioural model. That model applies each write before it evaluates the following read, so a stale alias value, a missed pulse or a merged pulse shows up as a mismatch in the exact cycle where it occurs.

// File: rtl/phy_emu_pkg.sv
package phy_emu_pkg;

    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;

    localparam logic [ADDR_W-1:0] A_CTRL    = 5'd0;
    localparam logic [ADDR_W-1:0] A_STATUS  = 5'd1;
    localparam logic [ADDR_W-1:0] A_ADV     = 5'd4;
    localparam logic [ADDR_W-1:0] A_PARTNER = 5'd5;

    localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7D00;
    localparam logic [DATA_W-1:0] ADV_WMASK  = 16'h07E0;
    localparam logic [4:0]        ADV_SEL    = 5'b00001;
    localparam int                CTRL_SRST  = 15;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ACK_RD  = 2'd1,
        ST_ACK_WR  = 2'd2,
        ST_ACK_NOP = 2'd3
    } ack_state_t;

    typedef struct packed {
        logic spd100;
        logic fdx;
        logic pause;
        logic link_n;
    } strap_t;

    function automatic logic [DATA_W-1:0] ctrl_default(input strap_t s);
        logic [DATA_W-1:0] v;
        v     = '0;
        v[13] = s.spd100;
        v[12] = 1'b1;
        v[8]  = s.fdx;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] adv_default(input strap_t s);
        logic [DATA_W-1:0] v;
        v      = '0;
        v[4:0] = ADV_SEL;
        v[5]   = 1'b1;
        v[6]   = s.fdx;
        v[7]   = s.spd100;
        v[8]   = s.spd100 & s.fdx;
        v[10]  = s.pause;
        return v;
    endfunction

endpackage

// File: rtl/phy_emu_ack_fsm.sv
module phy_emu_ack_fsm
    import phy_emu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    input  logic view_en,
    output logic rdy,
    output logic ack_is_read
);

    ack_state_t state_q;
    ack_state_t state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (req_valid) begin
            if (!view_en)
                state_d = ST_ACK_NOP;
            else if (req_write)
                state_d = ST_ACK_WR;
            else
                state_d = ST_ACK_RD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        rdy         = 1'b0;
        ack_is_read = 1'b0;
        unique case (state_q)
            ST_IDLE:    rdy = 1'b0;
            ST_ACK_RD: begin
                rdy         = 1'b1;
                ack_is_read = 1'b1;
            end
            ST_ACK_WR:  rdy = 1'b1;
            ST_ACK_NOP: rdy = 1'b1;
            default:    rdy = 1'b0;
        endcase
    end

endmodule

// File: rtl/phy_emu_decode.sv
module phy_emu_decode
    import phy_emu_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              view_en,
    output logic              wr_ctrl,
    output logic              wr_adv,
    output logic              rd_fire
);

    logic live;

    always_comb begin
        live    = req_valid & view_en;
        wr_ctrl = live & req_write & (req_addr == A_CTRL);
        wr_adv  = live & req_write & (req_addr == A_ADV);
        rd_fire = live & ~req_write;
    end

endmodule

// File: rtl/phy_emu_bank.sv
module phy_emu_bank
    import phy_emu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  strap_t            straps,
    input  logic              wr_ctrl,
    input  logic              wr_adv,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] adv_q
);

    logic soft_rst;

    assign soft_rst = wr_ctrl & wdata[CTRL_SRST];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= ctrl_default(straps);
        else if (soft_rst)
            ctrl_q <= ctrl_default(straps);
        else if (wr_ctrl)
            ctrl_q <= wdata & CTRL_WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            adv_q <= adv_default(straps);
        else if (soft_rst)
            adv_q <= adv_default(straps);
        else if (wr_adv)
            adv_q <= (wdata & ADV_WMASK) | {11'd0, ADV_SEL};
    end

endmodule

// File: rtl/phy_emu_status.sv
module phy_emu_status
    import phy_emu_pkg::*;
(
    input  strap_t            straps,
    output logic [DATA_W-1:0] status
);

    always_comb begin
        status     = '0;
        status[14] = straps.spd100 & straps.fdx;
        status[13] = straps.spd100;
        status[12] = straps.fdx;
        status[11] = 1'b1;
        status[5]  = 1'b1;
        status[3]  = 1'b1;
        status[2]  = ~straps.link_n;
    end

endmodule

// File: rtl/phy_emu_regs.sv
module phy_emu_regs
    import phy_emu_pkg::*;
#(
    parameter bit PARTNER_ALIAS = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              view_en,
    input  logic              strap_speed100,
    input  logic              strap_full_dup,
    input  logic              strap_pause,
    input  logic              strap_link_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rdy
);

    strap_t            straps;
    logic              wr_ctrl;
    logic              wr_adv;
    logic              rd_fire;
    logic              ack_is_read;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] adv_q;
    logic [DATA_W-1:0] status_w;
    logic [DATA_W-1:0] partner_w;
    logic [DATA_W-1:0] mux_w;
    logic [DATA_W-1:0] rd_q;

    assign straps = '{spd100: strap_speed100, fdx: strap_full_dup,
                      pause: strap_pause, link_n: strap_link_n};

    phy_emu_ack_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .view_en     (view_en),
        .rdy         (rdy),
        .ack_is_read (ack_is_read)
    );

    phy_emu_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .view_en   (view_en),
        .wr_ctrl   (wr_ctrl),
        .wr_adv    (wr_adv),
        .rd_fire   (rd_fire)
    );

    phy_emu_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .straps  (straps),
        .wr_ctrl (wr_ctrl),
        .wr_adv  (wr_adv),
        .wdata   (req_wdata),
        .ctrl_q  (ctrl_q),
        .adv_q   (adv_q)
    );

    phy_emu_status u_stat (
        .straps (straps),
        .status (status_w)
    );

    generate
        if (PARTNER_ALIAS) begin : g_alias
            assign partner_w = adv_q;
        end else begin : g_blank
            assign partner_w = '0;
        end
    endgenerate

    always_comb begin
        unique case (req_addr)
            A_CTRL:    mux_w = ctrl_q;
            A_STATUS:  mux_w = status_w;
            A_ADV:     mux_w = adv_q;
            A_PARTNER: mux_w = partner_w;
            default:   mux_w = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_q <= '0;
        else if (rd_fire)
            rd_q <= mux_w;
        else
            rd_q <= '0;
    end

    assign rd_data = ack_is_read ? rd_q : '0;

endmodule

// File: rtl/phy_emu_regs_chk.sv
module phy_emu_regs_chk
    import phy_emu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              view_en,
    input logic              strap_link_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              rdy,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [DATA_W-1:0] adv_q
);

    assert_ready_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rdy);

    assert_no_stray_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rdy);

    assert_link_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && view_en && req_addr == A_STATUS)
        |=> rd_data[2] == !$past(strap_link_n));

    assert_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && view_en && req_addr == A_PARTNER)
        |=> rd_data == $past(adv_q));

    assert_ignored_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr != A_CTRL && req_addr != A_ADV)
        |=> ($stable(ctrl_q) && $stable(adv_q)));

    assert_view_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !view_en) |=> (rd_data == '0 && $stable(ctrl_q) && $stable(adv_q)));

    assert_quiet_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |-> rd_data == '0);

endmodule

bind phy_emu_regs phy_emu_regs_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .view_en      (view_en),
    .strap_link_n (strap_link_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .rd_data      (rd_data),
    .rdy          (rdy),
    .ctrl_q       (ctrl_q),
    .adv_q        (adv_q)
);

// File: tb/phy_emu_regs_tb.sv
`timescale 1ns/1ps
module phy_emu_regs_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        view_en = 1'b1;
    logic        s_spd = 1'b1, s_dup = 1'b1, s_pau = 1'b1, s_lnk_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [15:0] rd_data;
    logic        rdy;

    int n_cmp = 0;
    int n_bad = 0;
    int m_ctrl, m_adv;

    always #2.5 clk = ~clk;

    phy_emu_regs u_dut (
        .clk(clk), .rst_n(rst_n), .view_en(view_en),
        .strap_speed100(s_spd), .strap_full_dup(s_dup),
        .strap_pause(s_pau), .strap_link_n(s_lnk_n),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rdy(rdy)
    );

    function automatic int ctrl_rst();
        return (int'(s_spd) << 13) | (1 << 12) | (int'(s_dup) << 8);
    endfunction

    function automatic int adv_rst();
        return 1 | (1 << 5) | (int'(s_dup) << 6) | (int'(s_spd) << 7)
             | (int'(s_spd & s_dup) << 8) | (int'(s_pau) << 10);
    endfunction

    function automatic int stat_val();
        return (int'(s_spd & s_dup) << 14) | (int'(s_spd) << 13) | (int'(s_dup) << 12)
             | (1 << 11) | (1 << 5) | (1 << 3) | (int'(!s_lnk_n) << 2);
    endfunction

    function automatic int model_read(input int a);
        case (a)
            0:       return m_ctrl;
            1:       return stat_val();
            4, 5:    return m_adv;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input bit e_rdy, input int e_data, input string tag);
        n_cmp++;
        if (rdy !== e_rdy || rd_data !== e_data[15:0]) begin
            n_bad++;
            $display("FAIL %s rdy=%0b exp %0b rd_data=%h exp %h",
                     tag, rdy, e_rdy, rd_data, e_data[15:0]);
        end
    endtask

    task automatic step(input bit v, input bit w, input int a, input int d, input string tag);
        bit e_rdy;
        int e_data;
        req_valid = v; req_write = w; req_addr = a[4:0]; req_wdata = d[15:0];
        e_rdy  = v;
        e_data = (v && !w && view_en) ? model_read(a) : 0;
        if (v && w && view_en) begin
            if (a == 0) begin
                if (d[15]) begin
                    m_ctrl = ctrl_rst();
                    m_adv  = adv_rst();
                end else begin
                    m_ctrl = d & 16'h7D00;
                end
            end else if (a == 4) begin
                m_adv = (d & 16'h07E0) | 1;
            end
        end
        @(posedge clk);
        #1;
        compare(e_rdy, e_data, tag);
    endtask

    task automatic do_reset();
        req_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        compare(1'b0, 0, "R1 reset");
        m_ctrl = ctrl_rst();
        m_adv  = adv_rst();
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        step(0, 0, 0, 0, "R1 idle");
        step(1, 0, 0, 0, "R2 ctrl reset");
        step(1, 0, 1, 0, "R3 status");
        step(1, 0, 4, 0, "R4 adv reset");
        step(1, 0, 5, 0, "R5 alias reset");
        step(0, 0, 0, 0, "R1 gap");
        step(1, 1, 4, 16'hFFFF, "R8 adv write all");
        step(1, 0, 5, 0, "R5 alias after write");
        step(1, 0, 4, 0, "R8 adv readback");
        step(1, 1, 4, 16'h0000, "R8 adv write zero");
        step(1, 0, 5, 0, "R5 alias zero");
        step(1, 1, 0, 16'h7FFF, "R6 ctrl write");
        step(1, 0, 0, 0, "R6 ctrl readback");
        step(1, 1, 0, 16'h0200, "R6 bit9 clear");
        step(1, 0, 0, 0, "R6 bit9 reads 0");
        step(1, 1, 4, 16'h0420, "R8 adv partial");
        step(1, 1, 0, 16'h8000, "R7 soft reset");
        step(1, 0, 0, 0, "R7 ctrl restored");
        step(1, 0, 5, 0, "R7 adv restored via alias");
        step(1, 1, 1, 16'hFFFF, "R9 write status");
        step(1, 1, 5, 16'h0000, "R9 write partner");
        step(1, 1, 7, 16'hFFFF, "R9 write addr7");
        step(1, 1, 31, 16'h1234, "R9 write addr31");
        step(1, 0, 4, 0, "R9 adv unchanged");
        step(1, 0, 0, 0, "R9 ctrl unchanged");
        step(1, 0, 3, 0, "R9 read addr3");
        step(1, 0, 31, 0, "R9 read addr31");
        s_lnk_n = 1'b1;
        step(1, 0, 1, 0, "R3 link down");
        s_lnk_n = 1'b0;
        view_en = 1'b0;
        step(1, 1, 4, 16'h0000, "R10 write while off");
        step(1, 0, 4, 0, "R10 read while off");
        step(1, 1, 0, 16'h8000, "R10 soft reset while off");
        view_en = 1'b1;
        step(1, 0, 4, 0, "R10 adv kept");
        step(1, 1, 4, 16'h0040, "R11 write data quiet");
        step(0, 0, 0, 0, "R11 idle quiet");
        s_spd = 1'b0; s_dup = 1'b0; s_pau = 1'b0;
        do_reset();
        step(1, 0, 0, 0, "R2 ctrl reset slow");
        step(1, 0, 1, 0, "R3 status slow");
        step(1, 0, 4, 0, "R4 adv reset slow");
        s_spd = 1'b1; s_dup = 1'b0; s_pau = 1'b1;
        do_reset();
        step(1, 0, 4, 0, "R4 adv reset mixed");
        step(1, 0, 0, 0, "R2 ctrl reset mixed");
        for (int i = 0; i < 300; i++) begin
            int a, d;
            bit v, w;
            v = ((i * 7) % 5) != 0;
            w = ((i * 3) % 4) == 1;
            a = (i * 13) % 8;
            d = (i * 40503 + 12345) & 16'hFFFF;
            if ((i % 29) == 0) d = d & 16'h7FFF;
            view_en = (i % 17) != 3;
            step(v, w, a, d, "R1 R5 mixed traffic");
        end
        view_en = 1'b1;
        step(0, 0, 0, 0, "R1 final idle");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired rdy=%0b exp done", rdy);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule